// File: doc/BRIEF.md
# Correlating Branch Direction and Target Predictor

This block sits in the fetch stage of a pipelined processor. For every fetch address it returns, in the same cycle and without a clock edge in between, a guess of whether the branch at that address is taken and an address to fetch next. The direction comes from a grid of two-bit saturating counters. Low word-address bits of the fetch PC pick a row of the grid. A short register holding the outcomes of the most recent resolved branches picks a column within that row. The next-fetch address comes from a small fully associative buffer of branch targets. When that buffer has no entry for the fetch address, the output falls back to the fetch address plus four.

Once a branch has been resolved in execute, the execute stage reports it through a single update port. The report carries the branch address, the real outcome and the computed target. At the next clock edge the block makes three changes. It moves the selected counter one step towards the outcome. It shifts the outcome into the history register. If the branch was taken, it either rewrites the matching target entry or claims a new one in first-in, first-out order.

Each counter is a four-state machine. The states are STRONG_NOT (00), WEAK_NOT (01), WEAK_TAKEN (10) and STRONG_TAKEN (11). A taken outcome moves a counter one step up: STRONG_NOT to WEAK_NOT, WEAK_NOT to WEAK_TAKEN, WEAK_TAKEN to STRONG_TAKEN, and STRONG_TAKEN stays where it is. A not-taken outcome moves it one step down in the same way and stays at STRONG_NOT. As a result, a counter in a strong state needs two wrong outcomes in a row before its guess flips.

Top module: `branch_guess_unit`

## Requirements
- R1: After reset every counter is WEAK_NOT (01), the history register is zero and every target entry is invalid. Every fetch then gives pred_taken=0, pred_hit=0 and pred_target=fetch_pc+4.
- R2: pred_taken is 1 when the selected counter is 10 or 11, and 0 when it is 00 or 01.
- R3: A taken update raises the selected counter by one step, saturating at 11. A not-taken update lowers it by one step, saturating at 00. From a strong state, the guess changes only after two opposite outcomes in a row.
- R4: The row is fetch_pc[ROW_BITS+1:2]. Bits [1:0] of the PC play no part in the row or column choice.
- R5: The column is the history register. On each update the history shifts left by one bit and takes the outcome into bit 0, where 1 means taken. Without an update the history is unchanged.
- R6: An update changes only the counter at the row of upd_pc and the column given by the history before this update's shift.
- R7: The target buffer compares the whole fetch_pc against every valid entry. On a hit, pred_hit=1 and pred_target is the stored target. On a miss, pred_hit=0 and pred_target=fetch_pc+4.
- R8: A taken update whose upd_pc is already held rewrites that entry's target in place. A taken update that misses fills the next slot in first-in, first-out order, so the ninth distinct address evicts the first. A not-taken update leaves the buffer unchanged.
- R9: The outputs depend only on fetch_pc and the stored state. An update becomes visible from the clock edge that ends its cycle, so a lookup in the same cycle as an update sees the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Guessed direction, 1 = taken |
| pred_hit | output | 1 | Target buffer holds fetch_pc |
| pred_target | output | PC_W | Stored target on a hit, otherwise fetch_pc+4 |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | PC_W | Computed target of the resolved branch |

## Verification
A lookup and an update can land in the same cycle, and they can land on the same counter or the same target entry. The bench causes this in two ways. Directed steps put the branch being updated on fetch_pc in the same cycle. Random steps draw fetch and update addresses from a small shared pool, so collisions happen often. In every collision the outputs must match the reference state from before the update, and the new state must appear only from the next cycle on.

// File: rtl/bgu_pkg.sv
package bgu_pkg;

    typedef enum logic [1:0] {
        STRONG_NOT   = 2'b00,
        WEAK_NOT     = 2'b01,
        WEAK_TAKEN   = 2'b10,
        STRONG_TAKEN = 2'b11
    } cnt_state_e;

    function automatic cnt_state_e cnt_step(input cnt_state_e cur, input logic taken);
        cnt_state_e nxt;
        unique case (cur)
            STRONG_NOT:   nxt = taken ? WEAK_NOT     : STRONG_NOT;
            WEAK_NOT:     nxt = taken ? WEAK_TAKEN   : STRONG_NOT;
            WEAK_TAKEN:   nxt = taken ? STRONG_TAKEN : WEAK_NOT;
            STRONG_TAKEN: nxt = taken ? STRONG_TAKEN : WEAK_TAKEN;
        endcase
        return nxt;
    endfunction

    function automatic logic cnt_guess(input cnt_state_e cur);
        logic g;
        unique case (cur)
            STRONG_NOT, WEAK_NOT:     g = 1'b0;
            WEAK_TAKEN, STRONG_TAKEN: g = 1'b1;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/bgu_dir_table.sv
module bgu_dir_table
    import bgu_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int ROW_BITS = 4,
    parameter int HIST_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            dir_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int IDX_W   = ROW_BITS + HIST_W;
    localparam int ENTRIES = 1 << IDX_W;

    cnt_state_e        cnt_q [ENTRIES];
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W:0]   hist_wide;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    cnt_state_e        wr_old;
    cnt_state_e        wr_new;

    always_comb begin
        rd_idx    = {fetch_pc[ROW_BITS+1:2], hist_q};
        wr_idx    = {upd_pc[ROW_BITS+1:2], hist_q};
        wr_old    = cnt_q[wr_idx];
        wr_new    = cnt_step(wr_old, upd_taken);
        hist_wide = {hist_q, upd_taken};
        dir_taken = cnt_guess(cnt_q[rd_idx]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                cnt_q[i] <= WEAK_NOT;
            end
            hist_q <= '0;
        end else if (upd_valid) begin
            cnt_q[wr_idx] <= wr_new;
            hist_q        <= hist_wide[HIST_W-1:0];
        end
    end

    p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist_q[0] == $past(upd_taken));

    p_hist_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist_q));

    p_ctr_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && wr_old != STRONG_TAKEN)
        |=> cnt_q[$past(wr_idx)] != $past(wr_old));

    p_ctr_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && wr_old == STRONG_NOT)
        |=> cnt_q[$past(wr_idx)] == STRONG_NOT);

endmodule

// File: rtl/bgu_target_buf.sv
module bgu_target_buf #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            look_hit,
    output logic [PC_W-1:0] look_target,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld_q;
    logic [PC_W-1:0]  tag_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];
    logic [PTR_W-1:0] fill_ptr_q;
    logic [DEPTH-1:0] look_vec;
    logic [DEPTH-1:0] upd_vec;
    logic             upd_any;
    logic [PTR_W-1:0] upd_slot;
    logic             do_alloc;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign look_vec[g] = vld_q[g] && (tag_q[g] == fetch_pc);
        assign upd_vec[g]  = vld_q[g] && (tag_q[g] == upd_pc);
    end

    always_comb begin
        look_target = '0;
        upd_slot    = '0;
        upd_any     = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (look_vec[i]) look_target = look_target | tgt_q[i];
            if (upd_vec[i]) begin
                upd_slot = PTR_W'(i);
                upd_any  = 1'b1;
            end
        end
        look_hit = |look_vec;
        do_alloc = upd_valid && upd_taken && !upd_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q      <= '0;
            fill_ptr_q <= '0;
        end else if (upd_valid && upd_taken) begin
            if (upd_any) begin
                tgt_q[upd_slot] <= upd_target;
            end else begin
                vld_q[fill_ptr_q] <= 1'b1;
                tag_q[fill_ptr_q] <= upd_pc;
                tgt_q[fill_ptr_q] <= upd_target;
                fill_ptr_q <= (fill_ptr_q == PTR_W'(DEPTH-1)) ? '0 : fill_ptr_q + 1'b1;
            end
        end
    end

    p_unique_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_vec));

    p_fill_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        do_alloc |=> fill_ptr_q != $past(fill_ptr_q));

    p_fill_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !do_alloc |=> $stable(fill_ptr_q) && $stable(vld_q));

endmodule

// File: rtl/branch_guess_unit.sv
module branch_guess_unit #(
    parameter int PC_W      = 32,
    parameter int ROW_BITS  = 4,
    parameter int HIST_W    = 2,
    parameter int BTB_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic            pred_hit,
    output logic [PC_W-1:0] pred_target,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic            tb_hit;
    logic [PC_W-1:0] tb_target;

    bgu_dir_table #(.PC_W(PC_W), .ROW_BITS(ROW_BITS), .HIST_W(HIST_W)) dir_i (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .dir_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    bgu_target_buf #(.PC_W(PC_W), .DEPTH(BTB_DEPTH)) tgt_i (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .look_hit(tb_hit), .look_target(tb_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    always_comb begin
        pred_hit    = tb_hit;
        pred_target = tb_hit ? tb_target : fetch_pc + STEP;
    end

    p_alloc_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken)
        |=> ((fetch_pc != $past(upd_pc)) ||
             (pred_hit && pred_target == $past(upd_target))));

endmodule

// File: tb/branch_guess_unit_tb_top.sv
module branch_guess_unit_tb_top;
    localparam int ROWB = 4;
    localparam int HW   = 2;
    localparam int DEP  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken, pred_hit;
    logic [31:0] pred_target;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int total = 0;
    int bad = 0;

    int          m_cnt [1<<(ROWB+HW)];
    int          m_hist;
    logic        m_vld [DEP];
    logic [31:0] m_tag [DEP];
    logic [31:0] m_tgt [DEP];
    int          m_ptr;

    always #2 clk = ~clk;

    branch_guess_unit dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_hit(pred_hit), .pred_target(pred_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    function automatic int m_idx(logic [31:0] pc);
        return (int'(pc[ROWB+1:2]) << HW) | m_hist;
    endfunction

    function automatic int m_slot(logic [31:0] pc);
        for (int i = 0; i < DEP; i++)
            if (m_vld[i] && m_tag[i] == pc) return i;
        return -1;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < (1<<(ROWB+HW)); i++) m_cnt[i] = 1;
        for (int i = 0; i < DEP; i++) m_vld[i] = 1'b0;
        m_hist = 0;
        m_ptr  = 0;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(logic [31:0] fpc, logic uv, logic [31:0] upc, logic ut,
                        logic [31:0] utgt, string req);
        int s;
        @(negedge clk);
        fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utgt;
        #1;
        s = m_slot(fpc);
        chk({req, " dir"}, {31'd0, pred_taken}, {31'd0, m_cnt[m_idx(fpc)] >= 2});
        chk({req, " hit"}, {31'd0, pred_hit}, {31'd0, s >= 0});
        chk({req, " tgt"}, pred_target, (s >= 0) ? m_tgt[s] : fpc + 32'd4);
        if (uv) begin
            int k;
            k = m_idx(upc);
            if (ut && m_cnt[k] < 3) m_cnt[k]++;
            if (!ut && m_cnt[k] > 0) m_cnt[k]--;
            m_hist = ((m_hist << 1) | int'(ut)) & ((1 << HW) - 1);
            if (ut) begin
                s = m_slot(upc);
                if (s >= 0) m_tgt[s] = utgt;
                else begin
                    m_vld[m_ptr] = 1'b1; m_tag[m_ptr] = upc; m_tgt[m_ptr] = utgt;
                    m_ptr = (m_ptr + 1) % DEP;
                end
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL R9 watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] pool [16];
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state across rows
        for (int i = 0; i < 6; i++) step(32'h1000 + i * 4, 1'b0, 0, 1'b0, 0, "R1");
        // R3/R2: drive a branch towards taken, then two wrongs flip it back
        for (int i = 0; i < 5; i++) step(32'h2040, 1'b1, 32'h2040, 1'b1, 32'h3000, "R3");
        step(32'h2040, 1'b0, 0, 1'b0, 0, "R2");
        for (int i = 0; i < 3; i++) step(32'h2040, 1'b1, 32'h2040, 1'b0, 32'h3000, "R3");
        step(32'h2040, 1'b0, 0, 1'b0, 0, "R3");
        // R4: low PC bits ignored for the counter choice; full compare in buffer
        step(32'h2043, 1'b0, 0, 1'b0, 0, "R4");
        step(32'h2041, 1'b1, 32'h2040, 1'b1, 32'h3100, "R4");
        step(32'h2042, 1'b0, 0, 1'b0, 0, "R4");
        // R5/R6: history picks the column
        step(32'h2080, 1'b1, 32'h2080, 1'b0, 0, "R5");
        step(32'h2080, 1'b1, 32'h2080, 1'b0, 0, "R5");
        step(32'h2080, 1'b1, 32'h2080, 1'b1, 32'h4000, "R6");
        step(32'h2080, 1'b0, 0, 1'b0, 0, "R6");
        // R8: fill beyond depth, evict oldest, refresh in place, not-taken no alloc
        for (int i = 0; i < DEP + 1; i++)
            step(32'h5000 + i * 64, 1'b1, 32'h5000 + i * 64, 1'b1, 32'h9000 + i, "R8");
        for (int i = 0; i < DEP + 1; i++) step(32'h5000 + i * 64, 1'b0, 0, 1'b0, 0, "R7");
        step(32'h5040, 1'b1, 32'h5040, 1'b1, 32'hABC0, "R8");
        step(32'h5040, 1'b1, 32'h7700, 1'b0, 32'h1234, "R8");
        step(32'h7700, 1'b0, 0, 1'b0, 0, "R8");
        // R9: lookup and update collide on the same address
        step(32'h6000, 1'b1, 32'h6000, 1'b1, 32'h6100, "R9");
        step(32'h6000, 1'b1, 32'h6000, 1'b1, 32'h6200, "R9");
        step(32'h6000, 1'b0, 0, 1'b0, 0, "R9");
        // Random mix over a small shared pool
        for (int i = 0; i < 16; i++) pool[i] = 32'h8000 + ($urandom % 64) * 4;
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] f, u;
            f = pool[$urandom % 16];
            u = ($urandom % 4 == 0) ? f : pool[$urandom % 16];
            step(f, ($urandom % 3) != 0, u, $urandom % 2, $urandom, "R6");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule